// File: doc/BRIEF.md
# Manchester Receive Front End with Violation-Based Message Sync

This block is the receive side of a slow serial radio data link. It oversamples a single data line and recovers half-bit symbols. It then decodes level-coded Manchester bit cells into bytes and queues them in a four-entry byte FIFO. Software reads the bytes one at a time through a pop strobe. A programmable divider sets the symbol rate: every half-bit symbol spans sixteen oversampling ticks, and the tick comes from the system clock divided by a fine factor and a coarse factor.

A message begins with a deliberate coding violation. The line sits low for at least one symbol and then stays high for two symbols. Before this pattern has been seen, no data reaches the FIFO. Each detection flushes the FIFO and restarts byte assembly, so every message lines up on its own byte boundaries. A cell whose two halves are both low, or both high without a preceding low symbol, ends synchronisation. The idle-low line after a message therefore returns the decoder to hunting.

An interrupt output has a selectable source: either the start detection or the FIFO being full. A sticky overrun flag marks a byte that was lost for lack of space.

Top module: `manch_rx_frontend`

## Requirements
- R1: The half-bit symbol lasts 16 × (fine_div + 1) × 2^coarse_div clock cycles. The receiver decodes correctly at any such setting when the line is driven at that rate.
- R2: A bit cell of high-then-low decodes as 1, and low-then-high decodes as 0. Bits fill each byte MSB first, and eight cells make one byte.
- R3: Three successive symbols low, high, high form a start. While synchronised, the two highs must fall in one bit cell. A start flushes the FIFO, sets byte assembly back to bit 0, and makes the next symbol the first half of a cell.
- R4: While not synchronised (`synced` = 0), no byte is written to the FIFO. A cell with two low halves, or two high halves not preceded by a low symbol, returns the decoder to the unsynchronised state and drops the partial byte.
- R5: Decoding runs only while both `rx_en` and `dec_en` are 1. Otherwise, from the next cycle on, the FIFO is empty, `overrun` is 0 and `synced` is 0.
- R6: The FIFO holds 4 bytes and `fifo_count` shows its fill level. A pop (`rd_en` = 1 with the FIFO not empty) puts the oldest byte on `rd_data` in the following cycle. A pop of an empty FIFO leaves `rd_data` and `fifo_count` unchanged.
- R7: A byte that completes while the FIFO holds 4 bytes, with no pop in that cycle, is dropped and sets `overrun`. `overrun` stays set, even across a start, until decoding is disabled.
- R8: With `irq_sel` = 3'b001, `irq` pulses high for one cycle, one cycle after a start detection. With `irq_sel` = 3'b100, `irq` is high one cycle after the FIFO holds 4 bytes and for as long as it does. Any other code keeps `irq` low.
- R9: After reset, `rd_data` = 0, `fifo_count` = 0, and `synced`, `overrun` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Asynchronous serial data line |
| rx_en | input | 1 | Receive enable |
| dec_en | input | 1 | Decoder enable |
| fine_div | input | 4 | Fine divider code, factor = code + 1 |
| coarse_div | input | 2 | Coarse divider code, factor = 2^code |
| irq_sel | input | 3 | Interrupt source: 001 start, 100 FIFO full |
| rd_en | input | 1 | Pop one byte from the FIFO |
| rd_data | output | 8 | Byte popped in the previous cycle |
| fifo_count | output | 3 | Bytes held in the FIFO |
| synced | output | 1 | Decoder is aligned to a message |
| overrun | output | 1 | Sticky lost-byte flag |
| irq | output | 1 | Interrupt request |

## Verification
A popped byte appears on `rd_data` one cycle after the `rd_en` cycle, so the bench raises `rd_en` for exactly one clock and compares at the following falling edge. A decoded byte reaches `fifo_count` a few oversampling ticks after its last half-bit is sampled. The start pulse and full-level interrupt follow their cause by one more register. For this reason the bench drives at least two idle symbols after every message before reading counts or flags, and it counts `irq` high cycles over the whole message instead of at one instant. Rate checks drive the line at the period from R1, so a wrong divider shows up as wrong bytes.

// File: rtl/manch_rx_pkg.sv
package manch_rx_pkg;

  localparam logic [2:0] IRQ_SRC_START = 3'b001;
  localparam logic [2:0] IRQ_SRC_FULL  = 3'b100;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } dec_state_t;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/manch_baud_gen.sv
module manch_baud_gen #(
  parameter int FINE_W   = 4,
  parameter int COARSE_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic [FINE_W-1:0]   fine,
  input  logic [COARSE_W-1:0] coarse,
  output logic                tick
);
  localparam int CNT_W = FINE_W + (1 << COARSE_W);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] fine_fac;
  logic [CNT_W-1:0] limit;

  assign fine_fac = CNT_W'(fine) + CNT_W'(1);
  assign limit    = (fine_fac << coarse) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= limit) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CNT_W'(1);
      tick <= 1'b0;
    end
  end

  // R1: tick only while running
  p_tick_needs_run_r1: assert property (@(posedge clk) disable iff (rst)
    !run |=> !tick);

endmodule

// File: rtl/manch_symbol_sampler.sv
module manch_symbol_sampler
  import manch_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic line_in,
  output logic sym_valid,
  output logic sym_level
);
  localparam int PH_W = $clog2(OSR);
  localparam int MID  = OSR / 2;

  logic            meta_q, sync_q, last_q;
  logic [PH_W-1:0] phase_q, ph_now;
  logic            v_early, v_mid;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= line_in;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    if (sync_q != last_q)
      ph_now = '0;
    else if (phase_q == PH_W'(OSR - 1))
      ph_now = '0;
    else
      ph_now = phase_q + PH_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      last_q    <= 1'b0;
      phase_q   <= '0;
      v_early   <= 1'b0;
      v_mid     <= 1'b0;
      sym_valid <= 1'b0;
      sym_level <= 1'b0;
    end else begin
      sym_valid <= 1'b0;
      if (tick) begin
        last_q  <= sync_q;
        phase_q <= ph_now;
        if (ph_now == PH_W'(MID - 1)) v_early <= sync_q;
        if (ph_now == PH_W'(MID))     v_mid   <= sync_q;
        if (ph_now == PH_W'(MID + 1)) begin
          sym_valid <= 1'b1;
          sym_level <= vote3(v_early, v_mid, sync_q);
        end
      end
    end
  end

  // R1: symbols are spaced by many ticks, never back to back
  p_sym_gap_r1: assert property (@(posedge clk) disable iff (rst)
    sym_valid |=> !sym_valid);

endmodule

// File: rtl/manch_frame_decoder.sv
module manch_frame_decoder
  import manch_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              sym_valid,
  input  logic              sym_level,
  output logic              start_pulse,
  output logic              byte_valid,
  output logic [DATA_W-1:0] byte_data,
  output logic              synced
);
  localparam int BC_W = $clog2(DATA_W);

  dec_state_t        state;
  logic              prev2, prev1;
  logic [BC_W-1:0]   bitcnt;
  logic [DATA_W-2:0] shreg;
  logic              start_cond;

  assign start_cond = sym_valid && !prev2 && prev1 && sym_level &&
                      (state == ST_HUNT || state == ST_SECOND);
  assign synced = (state != ST_HUNT);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      state       <= ST_HUNT;
      prev2       <= 1'b1;
      prev1       <= 1'b1;
      bitcnt      <= '0;
      shreg       <= '0;
      start_pulse <= 1'b0;
      byte_valid  <= 1'b0;
      byte_data   <= '0;
    end else begin
      start_pulse <= 1'b0;
      byte_valid  <= 1'b0;
      if (sym_valid) begin
        prev2 <= prev1;
        prev1 <= sym_level;
        if (start_cond) begin
          state       <= ST_FIRST;
          bitcnt      <= '0;
          start_pulse <= 1'b1;
        end else begin
          unique case (state)
            ST_FIRST: state <= ST_SECOND;
            ST_SECOND: begin
              if (prev1 != sym_level) begin
                state <= ST_FIRST;
                if (bitcnt == BC_W'(DATA_W - 1)) begin
                  byte_valid <= 1'b1;
                  byte_data  <= {shreg, prev1};
                  bitcnt     <= '0;
                end else begin
                  shreg  <= {shreg[DATA_W-3:0], prev1};
                  bitcnt <= bitcnt + BC_W'(1);
                end
              end else begin
                state <= ST_HUNT;
              end
            end
            default: state <= ST_HUNT;
          endcase
        end
      end
    end
  end

  // R4: nothing is emitted in the cycle after an unsynchronised cycle
  p_hunt_no_byte_r4: assert property (@(posedge clk) disable iff (rst)
    (!synced) |=> !byte_valid);
  // R3: a start never coincides with a completed byte
  p_start_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(start_pulse && byte_valid));

endmodule

// File: rtl/manch_rx_fifo.sv
module manch_rx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              ov_clear,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [$clog2(DEPTH):0] count,
  output logic              overrun
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = AW + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              pop, push;

  assign pop  = rd_en && (count != '0) && !flush;
  assign push = wr_en && !flush && ((count != CNT_W'(DEPTH)) || pop);

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (pop) begin
      rd_data <= mem[rptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= wptr + AW'(1);
      if (pop)  rptr <= rptr + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ov_clear) overrun <= 1'b0;
    else if (wr_en && !flush && !push) overrun <= 1'b1;
  end

  // R6: popping an empty FIFO with no write keeps it empty
  p_empty_pop_r6: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !wr_en) |=> (count == '0));
  // R7: a write into a full FIFO without a pop raises overrun
  p_full_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_W'(DEPTH) && wr_en && !rd_en && !flush && !ov_clear) |=> overrun);
  // R7: overrun is sticky
  p_ov_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ov_clear) |=> overrun);

endmodule

// File: rtl/manch_rx_frontend.sv
module manch_rx_frontend
  import manch_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int OSR        = 16,
  parameter int FINE_W     = 4,
  parameter int COARSE_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          line_in,
  input  logic                          rx_en,
  input  logic                          dec_en,
  input  logic [FINE_W-1:0]             fine_div,
  input  logic [COARSE_W-1:0]           coarse_div,
  input  logic [2:0]                    irq_sel,
  input  logic                          rd_en,
  output logic [DATA_W-1:0]             rd_data,
  output logic [$clog2(FIFO_DEPTH):0]   fifo_count,
  output logic                          synced,
  output logic                          overrun,
  output logic                          irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

  logic              active;
  logic              os_tick;
  logic              sym_valid, sym_level;
  logic              start_pulse, byte_valid;
  logic [DATA_W-1:0] byte_data;
  logic              fifo_full;

  assign active    = rx_en && dec_en;
  assign fifo_full = (fifo_count == CNT_W'(FIFO_DEPTH));

  manch_baud_gen #(.FINE_W(FINE_W), .COARSE_W(COARSE_W)) u_baud (
    .clk(clk), .rst(rst), .run(active),
    .fine(fine_div), .coarse(coarse_div), .tick(os_tick)
  );

  manch_symbol_sampler #(.OSR(OSR)) u_sampler (
    .clk(clk), .rst(rst), .run(active), .tick(os_tick),
    .line_in(line_in), .sym_valid(sym_valid), .sym_level(sym_level)
  );

  manch_frame_decoder #(.DATA_W(DATA_W)) u_decoder (
    .clk(clk), .rst(rst), .run(active),
    .sym_valid(sym_valid), .sym_level(sym_level),
    .start_pulse(start_pulse), .byte_valid(byte_valid),
    .byte_data(byte_data), .synced(synced)
  );

  manch_rx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .flush(start_pulse || !active), .ov_clear(!active),
    .wr_en(byte_valid), .wr_data(byte_data), .rd_en(rd_en),
    .rd_data(rd_data), .count(fifo_count), .overrun(overrun)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else irq <= active &&
                (((irq_sel == IRQ_SRC_START) && start_pulse) ||
                 ((irq_sel == IRQ_SRC_FULL) && fifo_full));
  end

  // R3: a start leaves an empty FIFO
  p_start_flush_r3: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> (fifo_count == '0));
  // R5: disabled decoding clears queue, flag and sync
  p_off_clear_r5: assert property (@(posedge clk) disable iff (rst)
    !active |=> (fifo_count == '0 && !overrun && !synced));
  // R8: full source follows the fill level
  p_irq_full_r8: assert property (@(posedge clk) disable iff (rst)
    (active && irq_sel == IRQ_SRC_FULL && fifo_full) |=> irq);
  // R8: unused source codes keep irq low
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_sel != IRQ_SRC_START && irq_sel != IRQ_SRC_FULL) |=> !irq);

endmodule

// File: tb/manch_rx_frontend_tb.sv
module manch_rx_frontend_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_in = 1'b0;
  logic       rx_en = 1'b0, dec_en = 1'b0, rd_en = 1'b0;
  logic [3:0] fine_div = 4'd0;
  logic [1:0] coarse_div = 2'd0;
  logic [2:0] irq_sel = 3'b000;
  logic [7:0] rd_data;
  logic [2:0] fifo_count;
  logic       synced, overrun, irq;

  int tests = 0, fails = 0, cycles = 0, irq_hits = 0, half = 16;
  bit done = 0;
  logic [7:0] msg [8];

  manch_rx_frontend dut_i (
    .clk(clk), .rst(rst), .line_in(line_in), .rx_en(rx_en), .dec_en(dec_en),
    .fine_div(fine_div), .coarse_div(coarse_div), .irq_sel(irq_sel),
    .rd_en(rd_en), .rd_data(rd_data), .fifo_count(fifo_count),
    .synced(synced), .overrun(overrun), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (irq) irq_hits++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int half_len(input int f, input int c);
    return 16 * (f + 1) * (1 << c);
  endfunction

  function automatic int exp_count(input int n);
    return (n > 4) ? 4 : n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_sym(input logic lvl);
    line_in = lvl;
    repeat (half) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    send_sym(b);
    send_sym(!b);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_msg(input int n);
    for (int i = 0; i < 4; i++) send_sym(1'b0);
    send_sym(1'b1);
    send_sym(1'b1);
    for (int i = 0; i < n; i++) send_byte(msg[i]);
    for (int i = 0; i < 3; i++) send_sym(1'b0);
  endtask

  task automatic pop_check(input string req, input logic [7:0] exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rd_data, exp);
  endtask

  task automatic set_rate(input int f, input int c);
    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    fine_div = 4'(f);
    coarse_div = 2'(c);
    half = half_len(f, c);
    rx_en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int base;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check("R9 rd_data", rd_data, 0);
    check("R9 fifo_count", fifo_count, 0);
    check("R9 flags", {synced, overrun, irq}, 0);

    rx_en = 1'b1; dec_en = 1'b1; irq_sel = 3'b001;
    repeat (2) @(negedge clk);
    // R4: data without a start pattern is discarded
    base = irq_hits;
    for (int i = 0; i < 4; i++) send_sym(1'b0);
    send_byte(8'hFF);
    send_byte(8'hFF);
    check("R4 no bytes before start", fifo_count, 0);
    check("R4 no start irq", irq_hits - base, 0);

    // R2 / R8 / R6: basic message with start interrupt
    msg[0] = 8'hA5; msg[1] = 8'h3C;
    base = irq_hits;
    send_msg(2);
    check("R8 one start pulse", irq_hits - base, 1);
    check("R4 idle returns to hunt", synced, 0);
    check("R6 count", fifo_count, 2);
    pop_check("R2 byte0", 8'hA5);
    pop_check("R2 byte1", 8'h3C);
    check("R6 count after pops", fifo_count, 0);
    pop_check("R6 empty pop keeps data", 8'h3C);
    check("R6 empty pop keeps count", fifo_count, 0);

    // R7 / R8: full interrupt and overrun
    irq_sel = 3'b100;
    msg[0] = 8'h01; msg[1] = 8'h02; msg[2] = 8'h04; msg[3] = 8'h08; msg[4] = 8'h10;
    send_msg(5);
    check("R7 count capped", fifo_count, exp_count(5));
    check("R8 full irq", irq, 1);
    check("R7 overrun set", overrun, 1);
    pop_check("R7 oldest kept", 8'h01);
    @(negedge clk);
    check("R8 full irq drops", irq, 0);

    // R3: a new start flushes unread bytes; R7 overrun survives start
    msg[0] = 8'h33;
    send_msg(1);
    check("R3 flush on start", fifo_count, 1);
    check("R7 overrun sticky", overrun, 1);
    pop_check("R3 new byte", 8'h33);

    // R3: resync in the middle of a byte restarts the bit count
    for (int i = 0; i < 4; i++) send_sym(1'b0);
    send_sym(1'b1); send_sym(1'b1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    send_sym(1'b1); send_sym(1'b1);
    send_byte(8'h5A);
    for (int i = 0; i < 3; i++) send_sym(1'b0);
    check("R3 resync count", fifo_count, 1);
    pop_check("R3 resync byte", 8'h5A);

    // R5: disable clears, decoder enable gates decoding
    msg[0] = 8'h77; msg[1] = 8'h66;
    send_msg(2);
    rx_en = 1'b0;
    @(negedge clk);
    check("R5 disable empties", fifo_count, 0);
    check("R5 disable clears overrun", overrun, 0);
    rx_en = 1'b1; dec_en = 1'b0;
    send_msg(2);
    check("R5 dec_en low no data", fifo_count, 0);
    check("R5 dec_en low no sync", synced, 0);
    dec_en = 1'b1;

    // R8: unused interrupt code
    irq_sel = 3'b000;
    base = irq_hits;
    msg[0] = 8'hC1; msg[1] = 8'h2E; msg[2] = 8'h99; msg[3] = 8'h40;
    send_msg(4);
    check("R8 quiet code", irq_hits - base, 0);
    check("R6 count quiet", fifo_count, 4);
    for (int i = 0; i < 4; i++) pop_check("R2 quiet bytes", msg[i]);

    // R1: other divider settings
    set_rate(12, 0);
    msg[0] = 8'hC3;
    send_msg(1);
    pop_check("R1 fine 12", 8'hC3);
    set_rate(2, 1);
    msg[0] = 8'h96; msg[1] = 8'h0F;
    send_msg(2);
    pop_check("R1 fine2 coarse1 a", 8'h96);
    pop_check("R1 fine2 coarse1 b", 8'h0F);

    // R1 / R2: random rates and payloads
    for (int k = 0; k < 6; k++) begin
      int n;
      set_rate($urandom_range(0, 3), $urandom_range(0, 1));
      n = $urandom_range(1, 4);
      for (int i = 0; i < n; i++) msg[i] = 8'($urandom());
      send_msg(n);
      check("R1 random count", fifo_count, exp_count(n));
      for (int i = 0; i < n; i++) pop_check("R2 random byte", msg[i]);
    end

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule